// File: doc/BRIEF.md
# FSK Modem Tone Synthesizer

This block is the digital transmit side of a 300-baud full-duplex low-speed modem. A 24-bit phase accumulator runs on the 3.579545 MHz reference clock. Each clock it advances by a tuning word, which is picked from the current bit, the signalling standard (Bell 103 or V.21) and the call direction (originate or answer). The top bits of the phase go through a folded quarter-wave sine table and come out as signed 8-bit samples for an external DAC.

The same control logic decodes the squelch, loopback and echo inputs into one operating mode. The block also publishes the tuning words of the two tones that the demodulator should look for. In self-test loopback these are the block's own transmit tones. Every tone scales in proportion to the reference clock rate. Filtering, line driving, hybrid and conversion are outside this block.

Top module: `fsk_tone_synth`

## Requirements
- R1: The phase accumulator is 24 bits wide and advances by the active tuning word on every clock. The tuning word for a tone of f Hz is round(f·2^24/3579545). Let p be accumulator bits [23:16]. The sample is registered from the accumulator value held before the clock edge, and is round(127·sin(2π(p+0.5)/256)) to within ±2 LSB.
- R2: With stdV21 low (Bell 103) and the originate side selected, the transmit tones are 1070 Hz when txData is low and 1270 Hz when txData is high. The expected receive tones are 2025 Hz (space) and 2225 Hz (mark). On the answer side the two pairs trade places.
- R3: With stdV21 high (V.21), channel 1 transmits 1180 Hz when txData is low and 980 Hz when txData is high. It expects to receive 1850 Hz (space) and 1650 Hz (mark). Channel 2 trades the two pairs.
- R4: originate high selects the originate side (channel 1). originate low selects the answer side (channel 2).
- R5: In echo mode the transmitted tone is a fixed 2225 Hz for Bell 103 or 2100 Hz for V.21, whatever txData is. The receive pair is the same as in normal operation.
- R6: While squelchEn is high, toneSample is 0 from the next clock and the accumulator is held at 0. On release, synthesis restarts from phase 0. The receive pair stays valid.
- R7: Power-down (squelchEn and loopEn both high) forces toneSample, rxSpaceTw and rxMarkTw to 0.
- R8: In loopback, rxSpaceTw and rxMarkTw carry the tuning words of the block's own transmit space and mark tones.
- R9: opMode codes the mode as 0 normal, 1 loopback, 2 echo, 3 squelch, 4 power-down. Power-down has the highest priority, then squelch, then echo, then loopback.
- R10: A change of tone changes only the increment. The accumulated phase carries on without a jump, so consecutive samples never differ by more than 4 LSB.
- R11: Every exported tuning word, converted back as tw·3579545/2^24, lies within 5 Hz of its nominal tone.
- R12: While rstN is low, toneSample is 0 and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| stdV21 | input | 1 | 1 = V.21 band plan, 0 = Bell 103 |
| originate | input | 1 | 1 = originate / channel 1, 0 = answer / channel 2 |
| txData | input | 1 | Bit to send: 1 mark, 0 space |
| loopEn | input | 1 | Analog self-test loopback request |
| squelchEn | input | 1 | Transmit mute request |
| echoEn | input | 1 | Echo-suppression tone request |
| toneSample | output | 8 | Signed sine sample, two's complement |
| opMode | output | 3 | Decoded operating mode (R9 codes) |
| rxSpaceTw | output | 24 | Tuning word of the expected receive space tone |
| rxMarkTw | output | 24 | Tuning word of the expected receive mark tone |

## Verification
The bench keeps its own accumulator and compares every sample against it, so any lost or reset phase shows up. A design that cleared the phase on a bit change, or that did not restart from zero after squelch, would drift away from the model within a few clocks. The bench toggles txData during echo tones: a generator that still keyed on the data would change pitch and fail. The control combinations are exercised with overlapping requests (echo with loopback, squelch with echo, squelch with loopback). These catch a wrong priority order, which would show up on opMode and on the receive words. A decoder that kept the normal receive pair in loopback would also be caught there.

// File: rtl/fsk_synth_pkg.sv
package fsk_synth_pkg;

  localparam int ACC_W = 24;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_LOOP    = 3'd1,
    MODE_ECHO    = 3'd2,
    MODE_SQUELCH = 3'd3,
    MODE_PDOWN   = 3'd4
  } opMode_e;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic [ACC_W-1:0] stepWord;
    logic             phaseClear;
  } synthCtl_t;

  // tone in Hz of one band: lowBand is the originate / channel 1 side
  function automatic int bandHz(input bit v21, input bit lowBand, input bit mark);
    if (lowBand) return v21 ? (mark ? 980 : 1180) : (mark ? 1270 : 1070);
    else         return v21 ? (mark ? 1650 : 1850) : (mark ? 2225 : 2025);
  endfunction

  function automatic int echoHz(input bit v21);
    return v21 ? 2100 : 2225;
  endfunction

  // rounded phase increment for a tone
  function automatic logic [ACC_W-1:0] hzToStep(input int hz, input longint refHz);
    longint num;
    num = longint'(hz) * (longint'(1) <<< ACC_W) + refHz / 2;
    return ACC_W'(num / refHz);
  endfunction

endpackage

// File: rtl/fsk_ctrl.sv
module fsk_ctrl
  import fsk_synth_pkg::*;
#(
  parameter longint REF_HZ = 3579545
) (
  input  logic             stdV21,
  input  logic             originate,
  input  logic             txData,
  input  logic             loopEn,
  input  logic             squelchEn,
  input  logic             echoEn,
  output synthCtl_t        ctl,
  output opMode_e          modeSel,
  output logic [ACC_W-1:0] rxSpaceStep,
  output logic [ACC_W-1:0] rxMarkStep
);

  // [standard][band: 0 low, 1 high][bit: 0 space, 1 mark]
  logic [ACC_W-1:0] stepTab [2][2][2];
  logic [ACC_W-1:0] echoStep;
  logic             txBand;
  logic             rxBand;

  for (genvar s = 0; s < 2; s++) begin : g_std
    for (genvar b = 0; b < 2; b++) begin : g_band
      for (genvar m = 0; m < 2; m++) begin : g_bit
        assign stepTab[s][b][m] = hzToStep(bandHz(s != 0, b == 0, m != 0), REF_HZ);
      end
    end
  end

  assign echoStep = stdV21 ? hzToStep(echoHz(1'b1), REF_HZ) : hzToStep(echoHz(1'b0), REF_HZ);

  always_comb begin
    if (squelchEn && loopEn) modeSel = MODE_PDOWN;
    else if (squelchEn)      modeSel = MODE_SQUELCH;
    else if (echoEn)         modeSel = MODE_ECHO;
    else if (loopEn)         modeSel = MODE_LOOP;
    else                     modeSel = MODE_NORMAL;
  end

  assign txBand = ~originate;
  assign rxBand = (modeSel == MODE_LOOP) ? txBand : ~txBand;

  always_comb begin
    ctl.stepWord   = (modeSel == MODE_ECHO) ? echoStep : stepTab[stdV21][txBand][txData];
    ctl.phaseClear = (modeSel == MODE_SQUELCH) || (modeSel == MODE_PDOWN);
  end

  always_comb begin
    if (modeSel == MODE_PDOWN) begin
      rxSpaceStep = '0;
      rxMarkStep  = '0;
    end else begin
      rxSpaceStep = stepTab[stdV21][rxBand][0];
      rxMarkStep  = stepTab[stdV21][rxBand][1];
    end
  end

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int IDX_W = 6,
  parameter int AMP_W = 7
) (
  input  logic [IDX_W-1:0] idx,
  output logic [AMP_W-1:0] mag
);

  localparam int DEPTH = 1 << IDX_W;
  localparam longint HALF_UNITS = 4 * DEPTH;   // half cycle in half-entry units
  localparam longint PEAK = (longint'(1) <<< AMP_W) - 1;

  // rational sine approximation at the centre of entry i
  function automatic logic [AMP_W-1:0] quarterMag(input int i);
    longint x, prod, num, den;
    x    = 2 * i + 1;
    prod = x * (HALF_UNITS - x);
    num  = 4 * prod * PEAK;
    den  = (5 * HALF_UNITS * HALF_UNITS) / 4 - prod;
    return AMP_W'((num + den / 2) / den);
  endfunction

  logic [AMP_W-1:0] tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [AMP_W-1:0] ENTRY = quarterMag(i);
    assign tab[i] = ENTRY;
  end

  assign mag = tab[idx];

endmodule

// File: rtl/fsk_datapath.sv
module fsk_datapath
  import fsk_synth_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  synthCtl_t                  ctl,
  output logic signed [SAMPLE_W-1:0] sample
);

  localparam int PH_W  = IDX_W + 2;
  localparam int AMP_W = SAMPLE_W - 1;

  logic [ACC_W-1:0]    acc;
  logic [PH_W-1:0]     phase;
  logic [1:0]          quad;
  logic [IDX_W-1:0]    romIdx;
  logic [AMP_W-1:0]    mag;
  logic [SAMPLE_W-1:0] posVal;
  logic [SAMPLE_W-1:0] foldVal;

  assign phase  = acc[ACC_W-1 -: PH_W];
  assign quad   = phase[PH_W-1 -: 2];
  assign romIdx = quad[0] ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];

  fsk_sine_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
    .idx (romIdx),
    .mag (mag)
  );

  assign posVal  = {1'b0, mag};
  assign foldVal = quad[1] ? (~posVal + 1'b1) : posVal;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.phaseClear) begin
      acc    <= '0;
      sample <= '0;
    end else begin
      acc    <= acc + ctl.stepWord;
      sample <= signed'(foldVal);
    end
  end

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
  import fsk_synth_pkg::*;
#(
  parameter longint REF_HZ    = 3579545,
  parameter int     SAMPLE_W  = 8,
  parameter int     LUT_IDX_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       stdV21,
  input  logic                       originate,
  input  logic                       txData,
  input  logic                       loopEn,
  input  logic                       squelchEn,
  input  logic                       echoEn,
  output logic signed [SAMPLE_W-1:0] toneSample,
  output logic [2:0]                 opMode,
  output logic [ACC_W-1:0]           rxSpaceTw,
  output logic [ACC_W-1:0]           rxMarkTw
);

  synthCtl_t ctl;
  opMode_e   modeSel;

  fsk_ctrl #(.REF_HZ(REF_HZ)) u_ctrl (
    .stdV21      (stdV21),
    .originate   (originate),
    .txData      (txData),
    .loopEn      (loopEn),
    .squelchEn   (squelchEn),
    .echoEn      (echoEn),
    .ctl         (ctl),
    .modeSel     (modeSel),
    .rxSpaceStep (rxSpaceTw),
    .rxMarkStep  (rxMarkTw)
  );

  fsk_datapath #(.SAMPLE_W(SAMPLE_W), .IDX_W(LUT_IDX_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .sample (toneSample)
  );

  assign opMode = modeSel;

endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk
  import fsk_synth_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       loopEn,
  input logic                       squelchEn,
  input logic                       echoEn,
  input logic signed [SAMPLE_W-1:0] toneSample,
  input logic [2:0]                 opMode,
  input logic [ACC_W-1:0]           rxSpaceTw,
  input logic [ACC_W-1:0]           rxMarkTw
);

  logic                     pastOk;
  logic                     prevMute;
  logic signed [SAMPLE_W-1:0] prevSample;
  logic signed [SAMPLE_W:0]   stepDiff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastOk     <= 1'b0;
      prevMute   <= 1'b1;
      prevSample <= '0;
    end else begin
      pastOk     <= 1'b1;
      prevMute   <= squelchEn;
      prevSample <= toneSample;
    end
  end

  assign stepDiff = {toneSample[SAMPLE_W-1], toneSample} - {prevSample[SAMPLE_W-1], prevSample};

  a_r12_reset_quiet: assert property (@(posedge clk) !rstN |=> toneSample == '0);

  a_r6_squelch_mutes: assert property (@(posedge clk) disable iff (!rstN)
    squelchEn |=> toneSample == '0);

  a_r7_pdown_rx_zero: assert property (@(posedge clk) disable iff (!rstN)
    (squelchEn && loopEn) |-> (rxSpaceTw == '0 && rxMarkTw == '0 && opMode == 3'd4));

  a_r9_squelch_wins: assert property (@(posedge clk) disable iff (!rstN)
    (squelchEn && !loopEn) |-> opMode == 3'd3);

  a_r9_echo_over_loop: assert property (@(posedge clk) disable iff (!rstN)
    (!squelchEn && echoEn) |-> opMode == 3'd2);

  a_r8_loop_mode: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !squelchEn && !echoEn) |-> opMode == 3'd1);

  a_r11_pair_distinct: assert property (@(posedge clk) disable iff (!rstN)
    !(squelchEn && loopEn) |-> rxSpaceTw != rxMarkTw);

  a_r10_no_phase_jump: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !prevMute) |-> (stepDiff <= 4 && stepDiff >= -4));

endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loopEn     (loopEn),
  .squelchEn  (squelchEn),
  .echoEn     (echoEn),
  .toneSample (toneSample),
  .opMode     (opMode),
  .rxSpaceTw  (rxSpaceTw),
  .rxMarkTw   (rxMarkTw)
);

// File: tb/sim_fsk_tone_synth.sv
`timescale 1ns/1ps
module sim_fsk_tone_synth;

  localparam longint REF = 3579545;
  localparam longint TWO24 = 16777216;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stdV21 = 1'b0, originate = 1'b0, txData = 1'b0;
  logic loopEn = 1'b0, squelchEn = 1'b0, echoEn = 1'b0;
  logic signed [7:0] toneSample;
  logic [2:0]        opMode;
  logic [23:0]       rxSpaceTw, rxMarkTw;

  int checks = 0;
  int errors = 0;
  bit wdFired = 0;

  logic [23:0] mAcc;
  int          expS;

  always #10 clk = ~clk;

  fsk_tone_synth u0 (
    .clk(clk), .rstN(rstN), .stdV21(stdV21), .originate(originate), .txData(txData),
    .loopEn(loopEn), .squelchEn(squelchEn), .echoEn(echoEn),
    .toneSample(toneSample), .opMode(opMode), .rxSpaceTw(rxSpaceTw), .rxMarkTw(rxMarkTw)
  );

  function automatic longint stepOf(input int hz);
    return (longint'(hz) * TWO24 + REF / 2) / REF;
  endfunction

  function automatic int bandTone(input bit v21, input bit low, input bit mark);
    if (low) return v21 ? (mark ? 980 : 1180) : (mark ? 1270 : 1070);
    return v21 ? (mark ? 1650 : 1850) : (mark ? 2225 : 2025);
  endfunction

  function automatic int txTone(input bit v21, input bit orig, input bit d, input bit echo);
    if (echo) return v21 ? 2100 : 2225;
    return bandTone(v21, orig, d);
  endfunction

  function automatic int rxTone(input bit v21, input bit orig, input bit lp, input bit mark);
    return bandTone(v21, lp ? orig : !orig, mark);
  endfunction

  function automatic int expMode(input bit sq, input bit lb, input bit ec);
    if (sq && lb) return 4;
    if (sq) return 3;
    if (ec) return 2;
    if (lb) return 1;
    return 0;
  endfunction

  function automatic int sinRef(input int p);
    real r;
    r = 127.0 * $sin(6.283185307179586 * (p + 0.5) / 256.0);
    return int'(r);
  endfunction

  // reference accumulator built from the requirements
  always @(posedge clk) begin
    if (!rstN || squelchEn) begin
      mAcc <= '0;
      expS <= 0;
    end else begin
      expS <= sinRef(int'(mAcc[23:16]));
      mAcc <= mAcc + 24'(stepOf(txTone(stdV21, originate, txData, echoEn)));
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stepCheck(input string sTag);
    int m;
    longint eSp, eMk;
    string rTag;
    @(negedge clk);
    check((int'(toneSample) - expS) <= 2 && (int'(toneSample) - expS) >= -2,
          sTag, "sample", int'(toneSample), expS);
    m = expMode(squelchEn, loopEn, echoEn);
    check(int'(opMode) == m, "R9", "opMode", opMode, m);
    if (m == 4) begin
      eSp = 0; eMk = 0; rTag = "R7";
    end else begin
      eSp = stepOf(rxTone(stdV21, originate, m == 1, 1'b0));
      eMk = stepOf(rxTone(stdV21, originate, m == 1, 1'b1));
      rTag = (m == 1) ? "R8" : (stdV21 ? "R3" : "R2");
    end
    check(rxSpaceTw == 24'(eSp), rTag, "rxSpaceTw", rxSpaceTw, eSp);
    check(rxMarkTw == 24'(eMk), rTag, "rxMarkTw", rxMarkTw, eMk);
  endtask

  task automatic runCycles(input int n, input int pct, input string sTag);
    for (int i = 0; i < n; i++) begin
      stepCheck(sTag);
      if (($urandom % 100) < pct) txData = ~txData;
    end
  endtask

  task automatic runAll();
    real hz;
    int nom;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(toneSample == 8'sd0, "R12", "sample in reset", toneSample, 0);
    rstN = 1'b1;

    // band plans, receive pairs and tuning accuracy
    for (int v = 0; v < 2; v++) begin
      for (int o = 0; o < 2; o++) begin
        for (int l = 0; l < 2; l++) begin
          stdV21 = v[0]; originate = o[0]; loopEn = l[0];
          runCycles(150, 3, v[0] ? "R3" : "R2");
          hz  = real'(rxSpaceTw) * real'(REF) / real'(TWO24);
          nom = rxTone(v[0], o[0], l[0], 1'b0);
          check(hz - nom <= 5.0 && nom - hz <= 5.0, "R11", "space Hz", longint'(hz), nom);
          hz  = real'(rxMarkTw) * real'(REF) / real'(TWO24);
          nom = rxTone(v[0], o[0], l[0], 1'b1);
          check(hz - nom <= 5.0 && nom - hz <= 5.0, "R11", "mark Hz", longint'(hz), nom);
          if (o == 1 && l == 0) begin
            nom = v[0] ? 1850 : 2025;
            check(rxSpaceTw == 24'(stepOf(nom)), "R4", "originate rx space", rxSpaceTw, stepOf(nom));
          end
        end
      end
    end
    loopEn = 1'b0;

    // frequent bit changes: phase must carry on
    stdV21 = 1'b0; originate = 1'b1;
    runCycles(1500, 20, "R10");

    // echo tone with data toggling, also with loopback requested
    for (int v = 0; v < 2; v++) begin
      stdV21 = v[0]; echoEn = 1'b1;
      runCycles(1200, 15, "R5");
      loopEn = 1'b1;
      runCycles(200, 15, "R5");
      loopEn = 1'b0; echoEn = 1'b0;
    end

    // squelch, then restart from phase 0
    squelchEn = 1'b1; echoEn = 1'b1;
    runCycles(40, 10, "R6");
    squelchEn = 1'b0; echoEn = 1'b0;
    stepCheck("R6");
    check((int'(toneSample) - sinRef(0)) <= 2 && (int'(toneSample) - sinRef(0)) >= -2,
          "R6", "restart sample", toneSample, sinRef(0));
    runCycles(300, 5, "R1");

    // power-down
    squelchEn = 1'b1; loopEn = 1'b1;
    runCycles(60, 10, "R7");
    squelchEn = 1'b0; loopEn = 1'b0;
    runCycles(100, 5, "R1");

    // random segments
    for (int s = 0; s < 30; s++) begin
      stdV21    = $urandom % 2;
      originate = $urandom % 2;
      loopEn    = ($urandom % 4) == 0;
      echoEn    = ($urandom % 5) == 0;
      squelchEn = ($urandom % 6) == 0;
      runCycles(300 + int'($urandom % 1200), 2, "R1");
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        #(64'd4000000);
        wdFired = 1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule